// File: doc/BRIEF.md
# Atomic Test-and-Set Shared Memory Controller

This block arbitrates a small on-chip word memory among several requesters. Each requester presents a request with an opcode, a word address and write data. It then holds that request until the controller answers with a one-cycle completion pulse. Ordinary reads and writes each take one memory cycle. The third operation, test-and-set, is the building block for mutual exclusion between requesters. It reads a word, returns the old contents to the requester, and stores the value 1 in the same word. The write follows the read at once, and no other requester can reach the memory between them.

The least significant bit of a word acts as a semaphore: 1 means the guarded resource is taken and 0 means it is free. A requester that gets 0 back from a test-and-set owns the resource. A requester that gets 1 back must try again later. In that case the rewrite of 1 leaves the word unchanged. The owner gives the resource back with an ordinary write of 0. While the read and the write of a test-and-set are in progress, the controller raises a bus lock output and holds its grant on the current owner. The lock falls as soon as the set is done. It is not held for the time the owner spends inside its critical section.

Top module: `sem_bus_ctrl`

## Requirements
- R1: When several requesters are pending while the controller is idle, the one with the lowest index wins. At most one grant bit is ever high.
- R2: A test-and-set (opcode 2) returns the whole old word of the addressed location to the winner. After it completes, that location holds the value 1.
- R3: The bus lock is high for exactly two consecutive cycles per test-and-set, the read cycle and the write cycle, and it is low at every other time.
- R4: From the cycle the controller accepts a request until the cycle after its completion pulse, the grant stays on the accepted requester. This holds even while the lock is high.
- R5: A read (opcode 0) and a write (opcode 1) each complete with a one-cycle done pulse two cycles after acceptance. A read returns the stored word on the shared read-data output during that pulse. A write stores its write data.
- R6: A test-and-set completes with a one-cycle done pulse three cycles after acceptance. The lock has already fallen in that cycle.
- R7: When two requesters issue test-and-set to the same free semaphore in the same cycle, exactly one of them receives 0.
- R8: After the owner writes 0 to a semaphore word, the next test-and-set on that word returns 0.
- R9: Opcode 3 behaves exactly like a read.
- R10: After reset, grant, done and lock are all low and every memory word reads 0.
- R11: A request that arrives while the controller is busy is not accepted until the current operation has finished. This holds even when the new request comes from a higher-priority requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Per-requester request, held until its done pulse |
| req_op | input | 2*NREQ | Per-requester opcode: 0 read, 1 write, 2 test-and-set, 3 read |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester write data |
| grant | output | NREQ | One-hot owner of the memory, zero when idle |
| done | output | NREQ | One-cycle completion pulse for the owner |
| rdata | output | DW | Read or old semaphore data, valid with done |
| bus_lock | output | 1 | High during the read and write cycles of a test-and-set |

## Verification
The hardest situation to reach is a true race: two requesters issue test-and-set to the same free word in the same clock edge, and neither may slip in between the other's read and write. The bench reaches this state by posting both requests in the same cycle, so both are pending at the same acceptance edge. It then checks that exactly one of them gets 0, and that the loser gets 1 only after the winner's write. It also posts all four requesters at once, so that the stimulus covers the priority order and requests that wait while the controller is busy.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore memory controller.
// Assumes a two-bit opcode field per requester.
package sem_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TAS   = 2'd2,
        OP_RSVD  = 2'd3
    } sem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_TAS_RD,
        ST_TAS_WR,
        ST_RESP
    } seq_state_e;
endpackage

// File: rtl/sem_prio_arb.sv
// Fixed-priority arbiter: the lowest-index active request wins.
// Purely combinational; the caller decides when the result is used.
module sem_prio_arb #(
    parameter int NREQ = 4,
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] win_oh,
    output logic [IDXW-1:0] win_idx,
    output logic            any_req
);
    logic [NREQ:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NREQ; i++) begin : g_chain
        // a request wins only if no lower index was active
        assign win_oh[i]   = req[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req[i];
    end

    assign any_req = seen[NREQ];

    // encode the one-hot winner into an index
    always_comb begin
        win_idx = '0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (req[k]) win_idx = IDXW'(k);
        end
    end
endmodule

// File: rtl/sem_mem_array.sv
// Single-port word memory: combinational read and synchronous write.
// Synchronous active-low reset clears every word to zero.
module sem_mem_array #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    // storage update: clear on reset, otherwise write when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/sem_seq_ctrl.sv
// Operation sequencer. It accepts one request while idle, runs a read or
// a write in one access cycle, or runs a locked read/write pair for
// test-and-set, and then gives a one-cycle response.
// Assumes each requester holds its request steady until its done pulse.
module sem_seq_ctrl
    import sem_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 8,
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*NREQ-1:0]  req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [DW*NREQ-1:0] req_wdata,
    input  logic [IDXW-1:0]  win_idx,
    input  logic             any_req,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NREQ-1:0]  grant,
    output logic [NREQ-1:0]  done,
    output logic             bus_lock,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic [DW-1:0]    rdata
);
    seq_state_e      state_q;
    logic [IDXW-1:0] owner_q;
    sem_op_e         op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   rdata_q;
    logic [NREQ-1:0] owner_oh;
    int unsigned     sel;

    assign sel = 32'(win_idx);

    // state, captured request and returned data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (any_req) begin
                    owner_q <= win_idx;
                    op_q    <= sem_op_e'(req_op[sel*2 +: 2]);
                    addr_q  <= req_addr[sel*AW +: AW];
                    wdata_q <= req_wdata[sel*DW +: DW];
                    state_q <= (sem_op_e'(req_op[sel*2 +: 2]) == OP_TAS)
                               ? ST_TAS_RD : ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (op_q != OP_WRITE) rdata_q <= mem_rdata;
                    state_q <= ST_RESP;
                end
                ST_TAS_RD: begin
                    rdata_q <= mem_rdata;
                    state_q <= ST_TAS_WR;
                end
                ST_TAS_WR: state_q <= ST_RESP;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // memory port drive and outward status
    always_comb begin
        owner_oh  = NREQ'(1) << owner_q;
        mem_addr  = addr_q;
        mem_we    = ((state_q == ST_ACCESS) && (op_q == OP_WRITE)) ||
                    (state_q == ST_TAS_WR);
        mem_wdata = (state_q == ST_TAS_WR) ? DW'(1) : wdata_q;
        grant     = (state_q != ST_IDLE) ? owner_oh : '0;
        done      = (state_q == ST_RESP) ? owner_oh : '0;
        bus_lock  = (state_q == ST_TAS_RD) || (state_q == ST_TAS_WR);
        rdata     = rdata_q;
    end

    // lock rises for one locked pair only: it stays high one more cycle
    assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |=> bus_lock);
    // and it never lasts a third cycle
    assert_lock_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && $past(bus_lock)) |=> !bus_lock);
    // single owner at any time
    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // grant held on its owner until the completion pulse
    assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && (done == '0)) |=> (grant == $past(grant)));
    // completion is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> (done == '0));
    // done only goes to the current owner, never while locked
    assert_done_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |-> ((done == grant) && !bus_lock));
endmodule

// File: rtl/sem_bus_ctrl.sv
// Top level: fixed-priority arbitration, operation sequencer and word
// memory. Inputs are flat vectors with one slice per requester.
module sem_bus_ctrl #(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 8,
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    req_valid,
    input  logic [2*NREQ-1:0]  req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [DW*NREQ-1:0] req_wdata,
    output logic [NREQ-1:0]    grant,
    output logic [NREQ-1:0]    done,
    output logic [DW-1:0]      rdata,
    output logic               bus_lock
);
    logic [NREQ-1:0] win_oh;
    logic [IDXW-1:0] win_idx;
    logic            any_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_we;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata;

    sem_prio_arb #(.NREQ(NREQ)) arb_i (
        .req     (req_valid),
        .win_oh  (win_oh),
        .win_idx (win_idx),
        .any_req (any_req)
    );

    sem_seq_ctrl #(.NREQ(NREQ), .AW(AW), .DW(DW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .win_idx   (win_idx),
        .any_req   (any_req),
        .mem_rdata (mem_rdata),
        .grant     (grant),
        .done      (done),
        .bus_lock  (bus_lock),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rdata     (rdata)
    );

    sem_mem_array #(.AW(AW), .DW(DW)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // the arbiter's pick is always an active request
    assert_arb_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> ((win_oh & req_valid) == win_oh) && $onehot(win_oh));
    // a write under lock always stores the set value into memory
    assert_tas_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && mem_we) |=> (mem_rdata == DW'(1)));
endmodule

// File: tb/sem_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module sem_bus_ctrl_tb_top;
    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [2*NREQ-1:0]  req_op = '0;
    logic [AW*NREQ-1:0] req_addr = '0;
    logic [DW*NREQ-1:0] req_wdata = '0;
    logic [NREQ-1:0]    grant, done;
    logic [DW-1:0]      rdata;
    logic               bus_lock;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lock_cycles = 0;
    logic [DW-1:0] result [NREQ];
    int order_q [$];

    // reference model state
    int m_left = 0;
    int m_owner = 0;
    int m_op = 0;
    logic [DW-1:0] m_mem [1 << AW];
    logic [DW-1:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    sem_bus_ctrl #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
        .done(done), .rdata(rdata), .bus_lock(bus_lock));

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model: one operation at a time, effect applied on acceptance
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0;
            for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        end else if (m_left > 0) begin
            m_left--;
        end else begin
            for (int r = NREQ - 1; r >= 0; r--)
                if (req_valid[r]) m_owner = r;
            if (req_valid != '0) begin
                int a;
                m_op = int'(req_op[m_owner*2 +: 2]);
                a = int'(req_addr[m_owner*AW +: AW]);
                if (m_op == 1) m_mem[a] = req_wdata[m_owner*DW +: DW];
                else m_rdata = m_mem[a];
                if (m_op == 2) m_mem[a] = DW'(1);
                m_left = (m_op == 2) ? 3 : 2;
            end
        end
    end

    // per-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            logic [NREQ-1:0] eg;
            eg = (m_left > 0) ? NREQ'(1) << m_owner : '0;
            if (bus_lock) lock_cycles++;
            chk(grant == eg, "R1/R4 grant", 32'(grant), 32'(eg));
            chk(bus_lock == (m_op == 2 && m_left >= 2), "R3 lock",
                32'(bus_lock), 32'(m_op == 2 && m_left >= 2));
            chk(done == ((m_left == 1) ? eg : '0), "R5/R6 done",
                32'(done), 32'((m_left == 1) ? eg : '0));
            if (m_left == 1 && m_op != 1)
                chk(rdata == m_rdata, "R2/R5 rdata", 32'(rdata), 32'(m_rdata));
        end
    end

    task automatic post(input int r, input int op, input int a, input int d);
        req_op[r*2 +: 2]     = 2'(op);
        req_addr[r*AW +: AW] = AW'(a);
        req_wdata[r*DW +: DW]= DW'(d);
        req_valid[r]         = 1'b1;
    endtask

    // run until every posted request has completed
    task automatic drain();
        int n = 0;
        do begin
            @(negedge clk); #1;
            for (int r = 0; r < NREQ; r++)
                if (req_valid[r] && done[r]) begin
                    req_valid[r] = 1'b0;
                    result[r] = rdata;
                    order_q.push_back(r);
                end
            n++;
        end while ((req_valid != '0 || m_left != 0) && n < 60);
        if (n >= 60) chk(1'b0, "drain timeout", 32'(n), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(grant == '0 && done == '0 && !bus_lock, "R10 reset outputs",
            {grant, done, 7'd0, bus_lock}, 32'd0);
        post(2, 0, 5, 0); drain();
        chk(result[2] == 0, "R10 memory zero", 32'(result[2]), 32'd0);
        // R5: write then read back
        post(1, 1, 3, 8'hA5); drain();
        post(3, 0, 3, 0); drain();
        chk(result[3] == 8'hA5, "R5 read back", 32'(result[3]), 32'hA5);
        // R7 / R1: simultaneous test-and-set on a free semaphore
        post(1, 2, 7, 0); post(2, 2, 7, 0);
        lock_cycles = 0;
        drain();
        chk(((result[1] == 0) ? 1 : 0) + ((result[2] == 0) ? 1 : 0) == 1,
            "R7 single winner", {result[1], result[2]}, 32'h0001);
        chk(result[1] == 0, "R1 low index wins", 32'(result[1]), 32'd0);
        chk(result[2] == 1, "R2 loser sees set", 32'(result[2]), 32'd1);
        chk(lock_cycles == 4, "R3 lock per tas", 32'(lock_cycles), 32'd4);
        post(0, 0, 7, 0); drain();
        chk(result[0] == 1, "R2 word holds 1", 32'(result[0]), 32'd1);
        // R8: release then reacquire
        post(1, 1, 7, 0); drain();
        post(2, 2, 7, 0); drain();
        chk(result[2] == 0, "R8 reacquire", 32'(result[2]), 32'd0);
        // R2: whole old word returned, then word becomes 1
        post(3, 2, 3, 0); drain();
        chk(result[3] == 8'hA5, "R2 old word", 32'(result[3]), 32'hA5);
        // R9: opcode 3 reads
        post(0, 3, 3, 8'hFF); drain();
        chk(result[0] == 1, "R9 op3 reads", 32'(result[0]), 32'd1);
        // R1 / R11: all four at once, completion in index order
        order_q.delete();
        post(3, 0, 3, 0); post(2, 2, 9, 0); post(1, 1, 9, 8'h40); post(0, 0, 7, 0);
        drain();
        for (int i = 0; i < NREQ; i++)
            chk(order_q[i] == i, "R1 order", 32'(order_q[i]), 32'(i));
        chk(result[2] == 8'h40, "R11 waited tas", 32'(result[2]), 32'h40);
        // R11: higher priority arrives while busy; no preemption
        order_q.delete();
        post(3, 2, 11, 0);
        @(negedge clk); #1;
        post(0, 0, 11, 0);
        drain();
        chk(order_q[0] == 3, "R11 no preempt", 32'(order_q[0]), 32'd3);
        chk(result[0] == 1, "R11 read after set", 32'(result[0]), 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule